// File: doc/BRIEF.md
# Processing State and Exception Entry Sequencer

This block keeps track of which processing state a processor core is in and carries out the whole exception entry sequence on the core's behalf. The four reported states are normal execution, stopped, exception processing and halted. Stopped is a quiet form of normal execution that is entered by a stop strobe. Halted is a terminal fault state. The block owns the status word: a trace flag, a supervisor flag, a three-bit interrupt priority mask and five condition flags.

When an event is accepted, the block does the following in order:
- It captures the current status word and the core's program counter.
- It forces supervisor mode and clears trace. For an interrupt, it raises the priority mask to the level being serviced.
- It picks the vector number.
- It writes three words below the supervisor stack pointer through a simple request/acknowledge memory port.
- It reads the handler address from the vector table and hands it to the core with a load pulse.

After reset the block fetches the initial stack pointer and program counter from the bottom of the table. A bus error that strikes while a bus-error frame is being built, or while the reset fetch is running, leaves the block halted until the next reset.

Top module: `psx_top`

## Requirements
- R1: While reset is low, sr_out is 0x2700 (supervisor set, trace clear, mask 7), mem_req is low and pstate is 2. After release, the block reads address 0 into ssp_out and then address 4 into pc_out, pulses pc_load for one cycle and enters pstate 0.
- R2: pstate encodes normal as 0, stopped as 1, exception processing as 2 and halted as 3.
- R3: stop_req in the normal state loads the status word from stop_sr masked with 0xA71F (bit 15 trace, bit 13 supervisor, bits 10:8 mask, bits 4:0 flags) and enters the stopped state one cycle later. While stopped, mem_req stays low and trap_req and trace_req are not accepted.
- R4: An interrupt is accepted when irq_level is non-zero and either exceeds the current mask or equals 7. An accepted interrupt also ends the stopped state. A level equal to the mask is ignored.
- R5: When several requests are present in the normal state, bus_err is served first, then the interrupt, then trap_req, then trace_req.
- R6: In the cycle after acceptance, pstate is 2, trace is clear and supervisor is set. An interrupt sets the mask to irq_level; other events leave the mask unchanged.
- R7: The frame is three writes, each to ssp_out minus 4, with ssp_out decremented as each write completes. The words are, in order: pc_in, the old status word zero-extended, and a format/vector word holding vector×4 in bits 11:0 with format 0 in bits 15:12.
- R8: After the frame, the block reads address vector×4, places the data on pc_out with a one-cycle pc_load pulse and returns to pstate 0.
- R9: Vector numbers are 2 for a bus error, 9 for trace, trap_vec for a trap and irq_vec for an interrupt.
- R10: A bus error during the frame or vector read of any other event restarts the sequence as a bus-error event (vector 2). The restarted sequence stacks the same captured program counter and status word, starting from the current stack pointer.
- R11: A bus error during a bus-error sequence, or during the reset fetch, enters pstate 3. In that state mem_req stays low, no request is accepted, and only reset leaves it.
- R12: Every access is word aligned. Address, direction and data stay stable while mem_req waits for mem_ack or bus_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_level | input | 3 | Requested interrupt level, 0 means none |
| irq_vec | input | VW | Vector number for the interrupt |
| trap_req | input | 1 | Trap instruction request |
| trap_vec | input | VW | Vector number for the trap |
| trace_req | input | 1 | Trace request after an instruction |
| stop_req | input | 1 | Stop strobe |
| stop_sr | input | 16 | Status word loaded by the stop strobe |
| pc_in | input | DW | Program counter value to be stacked |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | DW | Byte address |
| mem_wdata | output | DW | Write data |
| mem_rdata | input | DW | Read data |
| mem_ack | input | 1 | Access completed |
| bus_err | input | 1 | Access failed, or core bus error while running |
| pc_out | output | DW | Program counter handed to the core |
| pc_load | output | 1 | One-cycle pulse when pc_out is new |
| ssp_out | output | DW | Supervisor stack pointer |
| sr_out | output | 16 | Status word |
| pstate | output | 2 | Processing state |

## Verification
Acceptance is registered. A request driven between edges therefore shows up as pstate 2 with the new status word exactly one edge later, and the bench checks those values at the falling edge that follows that single edge. Each memory access completes on the edge that samples mem_ack, and the memory model decides the acknowledge at a falling edge. The scoreboard therefore compares each write's address and data at the falling edge where the acknowledge is granted, which is the cycle in which the access is consumed. pc_load and the new pc_out appear one edge after the vector read completes, and the bench polls falling edges for that pulse rather than assuming a fixed frame length. This lets injected wait and error cycles shift the timing without breaking the checks.

// File: rtl/psx_pkg.sv
`timescale 1ns/1ps
package psx_pkg;
  localparam int unsigned IPL_W     = 3;
  localparam int unsigned SR_T      = 15;
  localparam int unsigned SR_S      = 13;
  localparam int unsigned SR_IM_HI  = 10;
  localparam int unsigned SR_IM_LO  = 8;
  localparam logic [15:0] SR_WMASK  = 16'hA71F;
  localparam logic [15:0] SR_RESET  = 16'h2700;
  localparam int unsigned VEC_BERR  = 2;
  localparam int unsigned VEC_TRACE = 9;

  typedef enum logic [1:0] {
    PS_NORMAL  = 2'd0,
    PS_STOPPED = 2'd1,
    PS_EXCEPT  = 2'd2,
    PS_HALTED  = 2'd3
  } pstate_e;

  typedef enum logic [3:0] {
    SQ_RSP, SQ_RPC, SQ_RUN, SQ_STOP,
    SQ_PPC, SQ_PSR, SQ_PFV, SQ_VEC, SQ_HALT
  } seq_e;
endpackage

// File: rtl/psx_accept.sv
`timescale 1ns/1ps
module psx_accept import psx_pkg::*; #(
  parameter int unsigned VW = 8
) (
  input  logic             in_run,
  input  logic             in_stop,
  input  logic             bus_err,
  input  logic [IPL_W-1:0] irq_level,
  input  logic [VW-1:0]    irq_vec,
  input  logic [IPL_W-1:0] mask,
  input  logic             trap_req,
  input  logic [VW-1:0]    trap_vec,
  input  logic             trace_req,
  output logic             take,
  output logic             take_irq,
  output logic             take_berr,
  output logic [VW-1:0]    take_vec
);
  logic irq_ok;

  always_comb begin
    irq_ok    = (irq_level != '0) && ((irq_level > mask) || (irq_level == '1));
    take      = 1'b0;
    take_irq  = 1'b0;
    take_berr = 1'b0;
    take_vec  = '0;
    if (in_run) begin
      if (bus_err) begin
        take = 1'b1; take_berr = 1'b1; take_vec = VW'(VEC_BERR);
      end else if (irq_ok) begin
        take = 1'b1; take_irq = 1'b1; take_vec = irq_vec;
      end else if (trap_req) begin
        take = 1'b1; take_vec = trap_vec;
      end else if (trace_req) begin
        take = 1'b1; take_vec = VW'(VEC_TRACE);
      end
    end else if (in_stop && irq_ok) begin
      take = 1'b1; take_irq = 1'b1; take_vec = irq_vec;
    end
  end
endmodule

// File: rtl/psx_sr.sv
`timescale 1ns/1ps
module psx_sr import psx_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ent,
  input  logic             ent_irq,
  input  logic [IPL_W-1:0] ent_lvl,
  input  logic             stop_ld,
  input  logic [15:0]      stop_val,
  output logic [15:0]      sr_q
);
  logic        sr_en;
  logic [15:0] sr_d;

  always_comb begin
    sr_en = ent | stop_ld;
    sr_d  = sr_q;
    if (ent) begin
      sr_d[SR_T] = 1'b0;
      sr_d[SR_S] = 1'b1;
      if (ent_irq) sr_d[SR_IM_HI:SR_IM_LO] = ent_lvl;
    end else if (stop_ld) begin
      sr_d = stop_val & SR_WMASK;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sr_q <= SR_RESET;
    else if (sr_en) sr_q <= sr_d;
  end
endmodule

// File: rtl/psx_top.sv
`timescale 1ns/1ps
module psx_top import psx_pkg::*; #(
  parameter int unsigned DW = 32,
  parameter int unsigned VW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IPL_W-1:0] irq_level,
  input  logic [VW-1:0]    irq_vec,
  input  logic             trap_req,
  input  logic [VW-1:0]    trap_vec,
  input  logic             trace_req,
  input  logic             stop_req,
  input  logic [15:0]      stop_sr,
  input  logic [DW-1:0]    pc_in,
  output logic             mem_req,
  output logic             mem_we,
  output logic [DW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ack,
  input  logic             bus_err,
  output logic [DW-1:0]    pc_out,
  output logic             pc_load,
  output logic [DW-1:0]    ssp_out,
  output logic [15:0]      sr_out,
  output logic [1:0]       pstate
);
  localparam int unsigned WB = DW / 8;
  localparam int unsigned SH = $clog2(WB);

  logic [1:0]    rsync_q;
  logic          run_en;
  seq_e          st_q, st_d;
  logic [DW-1:0] ssp_q, ssp_d, pc_q, pc_d, spc_q;
  logic [15:0]   ssr_q, sr_q;
  logic [VW-1:0] vec_q, vec_d;
  logic          bep_q, bep_d, ld_q, ld_d;
  logic          ssp_en, pc_en, cap_en, vec_en;
  logic          sr_stop;
  logic          take, take_irq, take_berr;
  logic [VW-1:0] take_vec;
  logic [DW-1:0] ssp_dec, vec_addr;
  logic [11:0]   fv_ofs;
  logic          xfer_ok, xfer_err;

  // reset release is synchronised to the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign run_en = rsync_q[1];

  psx_accept #(.VW(VW)) u_acc (
    .in_run(st_q == SQ_RUN), .in_stop(st_q == SQ_STOP), .bus_err(bus_err),
    .irq_level(irq_level), .irq_vec(irq_vec), .mask(sr_q[SR_IM_HI:SR_IM_LO]),
    .trap_req(trap_req), .trap_vec(trap_vec), .trace_req(trace_req),
    .take(take), .take_irq(take_irq), .take_berr(take_berr), .take_vec(take_vec)
  );

  psx_sr u_sr (
    .clk(clk), .rst_n(rst_n), .ent(cap_en), .ent_irq(take_irq),
    .ent_lvl(irq_level), .stop_ld(sr_stop), .stop_val(stop_sr), .sr_q(sr_q)
  );

  assign ssp_dec  = ssp_q - DW'(WB);
  assign vec_addr = DW'(vec_q) << SH;
  assign fv_ofs   = 12'(vec_q) << SH;
  assign xfer_err = mem_req & bus_err;
  assign xfer_ok  = mem_req & mem_ack & ~bus_err;

  // memory port
  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (st_q)
      SQ_RSP: mem_req = run_en;
      SQ_RPC: begin mem_req = 1'b1; mem_addr = DW'(WB); end
      SQ_PPC: begin mem_req = 1'b1; mem_we = 1'b1; mem_addr = ssp_dec; mem_wdata = spc_q; end
      SQ_PSR: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = ssp_dec;
        mem_wdata = {{(DW-16){1'b0}}, ssr_q};
      end
      SQ_PFV: begin
        mem_req = 1'b1; mem_we = 1'b1; mem_addr = ssp_dec;
        mem_wdata = {{(DW-16){1'b0}}, 4'h0, fv_ofs};
      end
      SQ_VEC: begin mem_req = 1'b1; mem_addr = vec_addr; end
      default: ;
    endcase
  end

  // sequencer next state
  always_comb begin
    st_d    = st_q;
    ssp_en  = 1'b0; ssp_d = ssp_dec;
    pc_en   = 1'b0; pc_d  = mem_rdata;
    cap_en  = 1'b0;
    vec_en  = 1'b0; vec_d = take_vec; bep_d = take_berr;
    ld_d    = 1'b0;
    sr_stop = 1'b0;
    case (st_q)
      SQ_RSP: if (xfer_err) st_d = SQ_HALT;
              else if (xfer_ok) begin ssp_en = 1'b1; ssp_d = mem_rdata; st_d = SQ_RPC; end
      SQ_RPC: if (xfer_err) st_d = SQ_HALT;
              else if (xfer_ok) begin pc_en = 1'b1; ld_d = 1'b1; st_d = SQ_RUN; end
      SQ_RUN, SQ_STOP: begin
        if (take) begin
          cap_en = 1'b1; vec_en = 1'b1; st_d = SQ_PPC;
        end else if ((st_q == SQ_RUN) && stop_req) begin
          sr_stop = 1'b1; st_d = SQ_STOP;
        end
      end
      SQ_PPC, SQ_PSR, SQ_PFV, SQ_VEC: begin
        if (xfer_err) begin
          if (bep_q) st_d = SQ_HALT;
          else begin
            vec_en = 1'b1; vec_d = VW'(VEC_BERR); bep_d = 1'b1; st_d = SQ_PPC;
          end
        end else if (xfer_ok) begin
          case (st_q)
            SQ_PPC:  begin ssp_en = 1'b1; st_d = SQ_PSR; end
            SQ_PSR:  begin ssp_en = 1'b1; st_d = SQ_PFV; end
            SQ_PFV:  begin ssp_en = 1'b1; st_d = SQ_VEC; end
            default: begin pc_en = 1'b1; ld_d = 1'b1; st_d = SQ_RUN; end
          endcase
        end
      end
      default: st_d = SQ_HALT;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= SQ_RSP; ssp_q <= '0; pc_q <= '0; spc_q <= '0;
      ssr_q <= '0; vec_q <= '0; bep_q <= 1'b0; ld_q <= 1'b0;
    end else begin
      st_q <= st_d;
      ld_q <= ld_d;
      if (ssp_en) ssp_q <= ssp_d;
      if (pc_en)  pc_q  <= pc_d;
      if (cap_en) begin spc_q <= pc_in; ssr_q <= sr_q; end
      if (vec_en) begin vec_q <= vec_d; bep_q <= bep_d; end
    end
  end

  always_comb begin
    case (st_q)
      SQ_RUN:  pstate = PS_NORMAL;
      SQ_STOP: pstate = PS_STOPPED;
      SQ_HALT: pstate = PS_HALTED;
      default: pstate = PS_EXCEPT;
    endcase
  end

  assign pc_out  = pc_q;
  assign pc_load = ld_q;
  assign ssp_out = ssp_q;
  assign sr_out  = sr_q;
endmodule

// File: rtl/psx_chk.sv
`timescale 1ns/1ps
module psx_chk #(
  parameter int unsigned DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_req,
  input logic          mem_we,
  input logic [DW-1:0] mem_addr,
  input logic          mem_ack,
  input logic          bus_err,
  input logic          pc_load,
  input logic [DW-1:0] ssp_out,
  input logic [15:0]   sr_out,
  input logic [1:0]    pstate
);
  assert_stop_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pstate == 2'd1 |-> !mem_req);
  assert_entry_sr_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'd2 && $past(pstate) inside {2'd0, 2'd1}) |-> (!sr_out[15] && sr_out[13]));
  assert_frame_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && mem_ack && !bus_err) |=> ssp_out == $past(mem_addr));
  assert_load_normal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> pstate == 2'd0);
  assert_halt_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pstate == 2'd3 |-> !mem_req);
  assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pstate == 2'd3 |=> pstate == 2'd3);
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack && !bus_err) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_align_R12: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
endmodule

bind psx_top psx_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
  .mem_addr(mem_addr), .mem_ack(mem_ack), .bus_err(bus_err),
  .pc_load(pc_load), .ssp_out(ssp_out), .sr_out(sr_out), .pstate(pstate)
);

// File: tb/psx_top_tb_top.sv
`timescale 1ns/1ps
module psx_top_tb_top;
  typedef struct { logic [31:0] a; logic [31:0] d; string r; } wr_t;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic [2:0]  irq_level = '0;
  logic [7:0]  irq_vec = '0, trap_vec = '0;
  logic        trap_req = 1'b0, trace_req = 1'b0, stop_req = 1'b0;
  logic [15:0] stop_sr = '0;
  logic [31:0] pcin = '0;
  logic        mem_req, mem_we, pc_load;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, pc_out, ssp_out;
  logic [15:0] sr_out;
  logic [1:0]  pstate;
  logic        mem_ack = 1'b0, berr_mem = 1'b0, berr_core = 1'b0, bus_err;

  int vecs = 0, errs = 0, cyc = 0, err_n = 0;
  bit wd_hit = 1'b0, held_v = 1'b0;
  logic [31:0] held_a = '0, exp_ssp = '0;
  wr_t exq[$];
  wr_t e_w;

  function automatic logic [31:0] rd(input logic [31:0] a);
    if (a == 32'd0)      return 32'h0000_1000;
    else if (a == 32'd4) return 32'h0000_0400;
    else                 return 32'h0000_8000 + a;
  endfunction

  assign mem_rdata = rd(mem_addr);
  assign bus_err   = berr_mem | berr_core;

  psx_top dut_i (
    .clk(clk), .rst_n(rst_n), .irq_level(irq_level), .irq_vec(irq_vec),
    .trap_req(trap_req), .trap_vec(trap_vec), .trace_req(trace_req),
    .stop_req(stop_req), .stop_sr(stop_sr), .pc_in(pcin),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .bus_err(bus_err),
    .pc_out(pc_out), .pc_load(pc_load), .ssp_out(ssp_out), .sr_out(sr_out), .pstate(pstate)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  // driver side of the scoreboard: the three stack writes of one frame
  task automatic expect_frame(input logic [31:0] pc, input logic [15:0] sr,
                              input logic [7:0] vec, input string r);
    exq.push_back('{exp_ssp - 32'd4,  pc, {r, " R7 pc word"}});
    exq.push_back('{exp_ssp - 32'd8,  {16'h0, sr}, {r, " R7 status word"}});
    exq.push_back('{exp_ssp - 32'd12, {20'h0, vec, 4'h0} >> 2, {r, " R7 format/vector word"}});
    exp_ssp = exp_ssp - 32'd12;
  endtask

  task automatic wait_load(input string r, input logic [31:0] exp_pc);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (pc_load) break;
    end
    chk({r, " R8 pc_load pulse"}, {31'd0, pc_load}, 32'd1);
    chk({r, " R8 pc_out"}, pc_out, exp_pc);
    chk({r, " R8 back to normal"}, {30'd0, pstate}, 32'd0);
    chk({r, " R7 ssp_out"}, ssp_out, exp_ssp);
    chk({r, " R7 frame complete"}, exq.size(), 32'd0);
    exq.delete();
  endtask

  // memory model and scoreboard monitor, acting between edges
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000 && !wd_hit) begin
      wd_hit = 1'b1; errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
    if (!rst_n) begin
      mem_ack = 1'b0; berr_mem = 1'b0; held_v = 1'b0;
    end else if (mem_ack || berr_mem) begin
      mem_ack = 1'b0; berr_mem = 1'b0;
      held_v = mem_req; held_a = mem_addr;
    end else if (mem_req) begin
      if (held_v) chk("R12 request held", mem_addr, held_a);
      chk("R12 word aligned", {30'd0, mem_addr[1:0]}, 32'd0);
      held_v = 1'b0;
      if (err_n > 0) begin
        berr_mem = 1'b1; err_n--;
      end else begin
        mem_ack = 1'b1;
        if (mem_we) begin
          if (exq.size() == 0) begin
            vecs++; errs++;
            $display("FAIL R7 write addr=%h data=%h expected=none", mem_addr, mem_wdata);
          end else begin
            e_w = exq.pop_front();
            chk({e_w.r, " addr"}, mem_addr, e_w.a);
            chk({e_w.r, " data"}, mem_wdata, e_w.d);
          end
        end
      end
    end
  end

  task automatic hold_reset();
    rst_n = 1'b0;
    exq.delete();
    repeat (3) @(negedge clk);
    chk("R1 reset sr", {16'd0, sr_out}, 32'h2700);
    chk("R1 reset no request", {31'd0, mem_req}, 32'd0);
    chk("R1 reset pstate", {30'd0, pstate}, 32'd2);
  endtask

  task automatic boot();
    rst_n = 1'b1;
    exp_ssp = 32'h1000;
    wait_load("R1 boot", 32'h400);
  endtask

  initial begin
    bit bad;
    hold_reset();
    boot();
    pcin = 32'h0000_1234;

    // R3 stop with masked status load
    @(negedge clk); stop_req = 1'b1; stop_sr = 16'hA3F5;
    @(negedge clk); stop_req = 1'b0;
    chk("R3 R2 stopped pstate", {30'd0, pstate}, 32'd1);
    chk("R3 stop status", {16'd0, sr_out}, 32'hA315);
    trap_req = 1'b1; trace_req = 1'b1; irq_level = 3'd3; bad = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (mem_req || pstate != 2'd1) bad = 1'b1;
    end
    trap_req = 1'b0; trace_req = 1'b0;
    chk("R3 R4 stopped ignores trap/trace/equal level", {31'd0, bad}, 32'd0);

    // R4 interrupt wakes the stopped state
    irq_level = 3'd5; irq_vec = 8'h40;
    expect_frame(pcin, 16'hA315, 8'h40, "R4 wake");
    @(negedge clk); irq_level = 3'd0;
    chk("R4 R6 entry pstate", {30'd0, pstate}, 32'd2);
    chk("R6 entry status mask raised", {16'd0, sr_out}, 32'h2515);
    wait_load("R4 wake", 32'h8140 - 32'h40);

    // R4 level equal to mask ignored while running
    irq_level = 3'd5; bad = 1'b0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (pstate != 2'd0) bad = 1'b1;
    end
    irq_level = 3'd0;
    chk("R4 equal level ignored", {31'd0, bad}, 32'd0);

    // R5 interrupt beats trap and trace
    pcin = 32'h0000_2222;
    irq_level = 3'd6; irq_vec = 8'h41; trap_req = 1'b1; trap_vec = 8'h20; trace_req = 1'b1;
    expect_frame(pcin, 16'h2515, 8'h41, "R5 irq first");
    @(negedge clk); irq_level = 3'd0; trap_req = 1'b0; trace_req = 1'b0;
    chk("R6 interrupt mask", {16'd0, sr_out}, 32'h2615);
    wait_load("R5 irq first", 32'h8104);

    // R5 trap beats trace, R6 mask kept
    trap_req = 1'b1; trap_vec = 8'h20; trace_req = 1'b1;
    expect_frame(pcin, 16'h2615, 8'h20, "R5 trap first");
    @(negedge clk); trap_req = 1'b0; trace_req = 1'b0;
    chk("R6 trap keeps mask", {16'd0, sr_out}, 32'h2615);
    wait_load("R5 trap first", 32'h8080);

    // R5 R9 bus error beats everything, vector 2
    berr_core = 1'b1; irq_level = 3'd7; irq_vec = 8'h50; trap_req = 1'b1;
    expect_frame(pcin, 16'h2615, 8'h02, "R5 R9 bus error");
    @(negedge clk); berr_core = 1'b0; irq_level = 3'd0; trap_req = 1'b0;
    wait_load("R9 bus error", 32'h8008);

    // R9 trace vector 9
    trace_req = 1'b1;
    expect_frame(pcin, 16'h2615, 8'h09, "R9 trace");
    @(negedge clk); trace_req = 1'b0;
    wait_load("R9 trace", 32'h8024);

    // R10 bus error on first push restarts as bus-error event
    err_n = 1; trace_req = 1'b1;
    expect_frame(pcin, 16'h2615, 8'h02, "R10 restart");
    @(negedge clk); trace_req = 1'b0;
    wait_load("R10 restart", 32'h8008);

    // R4 level 7 accepted at mask 7
    @(negedge clk); stop_req = 1'b1; stop_sr = 16'h2700;
    @(negedge clk); stop_req = 1'b0;
    chk("R3 stopped again", {30'd0, pstate}, 32'd1);
    irq_level = 3'd7; irq_vec = 8'h50;
    expect_frame(pcin, 16'h2700, 8'h50, "R4 level 7");
    @(negedge clk); irq_level = 3'd0;
    chk("R4 level 7 accepted", {30'd0, pstate}, 32'd2);
    wait_load("R4 level 7", 32'h8140);

    // R11 double bus error halts
    err_n = 2; trap_req = 1'b1; trap_vec = 8'h21;
    @(negedge clk); trap_req = 1'b0;
    repeat (20) @(negedge clk);
    chk("R11 R2 halted", {30'd0, pstate}, 32'd3);
    irq_level = 3'd7; trap_req = 1'b1; bad = 1'b0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (mem_req || pstate != 2'd3) bad = 1'b1;
    end
    irq_level = 3'd0; trap_req = 1'b0;
    chk("R11 halted stays quiet", {31'd0, bad}, 32'd0);
    chk("R11 no stack writes", exq.size(), 32'd0);

    // R11 bus error during reset fetch
    hold_reset();
    err_n = 1;
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R11 reset fetch error halts", {30'd0, pstate}, 32'd3);

    // R1 reset leaves halted
    hold_reset();
    err_n = 0;
    boot();
    report();
  end
endmodule